// File: doc/BRIEF.md
# Pipelined Streaming Eight-Value Sorter

The block accepts a stream of unsigned words, at most one per clock, and collects them into groups of eight. When the eighth word of a group is captured, the whole group enters a fixed compare-and-swap network. The network has six compare levels and is cut into three register stages. Each stage therefore holds two compare levels. The next group can load while earlier groups are still moving through the network.

Each sorted group leaves serially, one word per clock, smallest first. The eighth word carries a last marker. A queue-select flag goes with every word and tells downstream logic which of two queues should store the group. The flag alternates from one group to the next, so that later logic can merge pairs of sorted runs. The block does no merging, generates no memory addresses and contains no queue storage.

Top module: `octet_sorter`

## Requirements
- R1: Each group is output in ascending unsigned order, smallest value first, as eight words on eight consecutive clocks.
- R2: Only cycles with `in_valid` high capture a word. Gaps in `in_valid` do not split or corrupt a group. While fewer than eight words of a group are captured, nothing from that group appears at the output.
- R3: The first word of a sorted group is valid after the fourth rising edge that follows the edge capturing the group's eighth word.
- R4: `out_last` is high exactly with the eighth word of each group. `out_valid` is low whenever no group is draining.
- R5: `out_queue` is 0 (first queue) for the first group after reset and inverts for every following group. It is constant across the eight words of a group.
- R6: With `in_valid` held high continuously, the sorted groups leave back to back with no idle cycle between them and no word lost.
- R7: Equal values are all kept. The output group is the same multiset as the input group.
- R8: A synchronous active-high `rst` makes `out_valid` low on the next cycle. It discards any partially loaded group, and the next group after reset goes to queue 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | W | Unsigned input word |
| out_valid | output | 1 | A sorted word is present on `out_data` |
| out_data | output | W | Sorted output word |
| out_last | output | 1 | Marks the eighth word of a group |
| out_queue | output | 1 | Destination queue: 0 = first, 1 = second |

## Verification
The assertions assume that words arrive at no more than one per clock. Under that assumption, a new group finishes the network no sooner than eight cycles after the previous one, so a drain is never cut short. The ascending-order and beat-count properties depend on this spacing.

The stimulus drives `in_valid` at most once per clock, sometimes with idle gaps and sometimes continuously. Reset is applied mid-group only while no drain is in progress, so that every drain the properties observe runs to completion.

// File: rtl/octet_sorter.sv
module octet_sorter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         out_queue
);
  localparam int N = 8;
  localparam int STAGES = 3;
  localparam int CW = $clog2(N);

  // Each 24-bit entry holds four compare pairs, two octal digits {lo_idx, hi_idx}; 00 = unused.
  localparam logic [23:0] NET [2*STAGES] = '{
    {6'o67, 6'o45, 6'o23, 6'o01},
    {6'o57, 6'o46, 6'o13, 6'o02},
    {6'o00, 6'o00, 6'o56, 6'o12},
    {6'o37, 6'o26, 6'o15, 6'o04},
    {6'o00, 6'o00, 6'o35, 6'o24},
    {6'o00, 6'o56, 6'o34, 6'o12}
  };

  function automatic logic [N*W-1:0] cas_level(input logic [N*W-1:0] v, input logic [23:0] pr);
    logic [W-1:0] e [N];
    logic [W-1:0] t;
    logic [2:0]   a, b;
    for (int i = 0; i < N; i++) e[i] = v[i*W +: W];
    for (int p = 0; p < 4; p++) begin
      a = pr[p*6+3 +: 3];
      b = pr[p*6 +: 3];
      if (a != b && !(e[a] < e[b])) begin
        t = e[a]; e[a] = e[b]; e[b] = t;
      end
    end
    for (int i = 0; i < N; i++) cas_level[i*W +: W] = e[i];
  endfunction

  logic [N*W-1:0] ld_buf;
  logic [CW-1:0]  ld_cnt;
  logic [N*W-1:0] stg [STAGES+1];
  logic           stv [STAGES+1];
  logic [N*W-1:0] nxt [STAGES];
  logic [N*W-1:0] dr_buf;
  logic [CW-1:0]  dr_cnt;
  logic           dr_act, q_next, q_cur;

  assign stg[0] = ld_buf;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign nxt[g] = cas_level(cas_level(stg[g], NET[2*g]), NET[2*g+1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_cnt <= '0;
      for (int s = 0; s <= STAGES; s++) stv[s] <= 1'b0;
    end else begin
      stv[0] <= in_valid && (ld_cnt == CW'(N-1));
      for (int s = 1; s <= STAGES; s++) stv[s] <= stv[s-1];
      if (in_valid) ld_cnt <= ld_cnt + 1'b1;
    end
    if (in_valid) ld_buf[ld_cnt*W +: W] <= in_data;
    for (int s = 1; s <= STAGES; s++) stg[s] <= nxt[s-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_act <= 1'b0;
      dr_cnt <= '0;
      q_next <= 1'b0;
      q_cur  <= 1'b0;
    end else if (stv[STAGES]) begin
      dr_buf <= stg[STAGES];
      dr_act <= 1'b1;
      dr_cnt <= '0;
      q_cur  <= q_next;
      q_next <= ~q_next;
    end else if (dr_act) begin
      dr_buf <= dr_buf >> W;
      dr_cnt <= dr_cnt + 1'b1;
      if (dr_cnt == CW'(N-1)) dr_act <= 1'b0;
    end
  end

  assign out_valid = dr_act;
  assign out_data  = dr_buf[W-1:0];
  assign out_last  = dr_act && (dr_cnt == CW'(N-1));
  assign out_queue = q_cur;
endmodule

module octet_sorter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_last,
  input logic         out_queue
);
  logic [3:0] beats;
  always_ff @(posedge clk) begin
    if (rst) beats <= '0;
    else if (out_valid) beats <= out_last ? 4'd0 : beats + 4'd1;
  end

  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |=> out_valid && out_data >= $past(out_data)); // R1
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |=> out_valid); // R1
  AST_LAST_ON_EIGHTH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last == (beats == 4'd7))); // R4
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R4
  AST_QUEUE_STEADY: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |=> $stable(out_queue)); // R5
  AST_QUEUE_FLIP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |=> !out_valid || out_queue != $past(out_queue)); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid); // R8
endmodule

bind octet_sorter octet_sorter_chk #(.W(W)) u_chk (.*);

// File: tb/octet_sorter_bench.sv
module octet_sorter_bench;
  localparam int W = 8;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [W-1:0] in_data = '0;
  logic out_valid, out_last, out_queue;
  logic [W-1:0] out_data;

  octet_sorter #(.W(W)) u_octet_sorter (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int got_d [64], got_c [64];
  logic got_l [64], got_q [64];
  int n_got = 0;

  always @(negedge clk) if (!rst && out_valid && n_got < 64) begin
    got_d[n_got] = out_data; got_l[n_got] = out_last;
    got_q[n_got] = out_queue; got_c[n_got] = cyc; n_got++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send8(input int v [8], input int gap, output int cap);
    for (int i = 0; i < 8; i++) begin
      in_valid = 1; in_data = W'(v[i]);
      @(negedge clk);
      in_valid = 0;
      repeat (gap) @(negedge clk);
    end
    cap = (gap == 0) ? cyc : cyc - gap;
  endtask

  task automatic wait_out(input int cnt);
    for (int t = 0; t < 200 && n_got < cnt; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_group(input int base, input int v [8], input int q, input int cap);
    int s [8];
    int t;
    s = v;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 7 - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    for (int k = 0; k < 8; k++) begin
      check(got_d[base+k] == s[k], "R1/R7 sorted word", got_d[base+k], s[k]);
      check(got_l[base+k] == (k == 7), "R4 last marker", got_l[base+k], k == 7);
      check(got_q[base+k] == q, "R5 queue flag", got_q[base+k], q);
      check(got_c[base+k] == cap + 4 + k, "R3 timing", got_c[base+k], cap + 4 + k);
    end
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R8 idle in reset", out_valid, 0);
    check(out_last == 0, "R4 no last in reset", out_last, 0);
    rst = 0; n_got = 0;
    @(negedge clk);
  endtask

  task automatic t_single();
    int v [8] = '{37, 5, 200, 5, 0, 255, 128, 64};
    int cap;
    send8(v, 0, cap);
    wait_out(8);
    check(n_got == 8, "R1 word count", n_got, 8);
    check_group(0, v, 0, cap);
    check(out_valid == 0, "R4 idle after drain", out_valid, 0);
  endtask

  task automatic t_alternate();
    int a [8] = '{8, 7, 6, 5, 4, 3, 2, 1};
    int b [8] = '{1, 2, 3, 4, 5, 6, 7, 8};
    int ca, cb;
    n_got = 0;
    send8(a, 0, ca); wait_out(8);
    send8(b, 0, cb); wait_out(16);
    check_group(0, a, 1, ca);
    check_group(8, b, 0, cb);
  endtask

  task automatic t_gaps();
    int v [8] = '{90, 91, 3, 250, 3, 3, 17, 1};
    int cap;
    n_got = 0;
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_data = W'(v[i]); @(negedge clk);
      in_valid = 0; repeat (2) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(n_got == 0, "R2 partial group held", n_got, 0);
    for (int i = 5; i < 8; i++) begin
      in_valid = 1; in_data = W'(v[i]); @(negedge clk);
      if (i == 7) cap = cyc;
      in_valid = 0; repeat (3) @(negedge clk);
    end
    wait_out(8);
    check_group(0, v, 1, cap);
  endtask

  task automatic t_stream();
    int g0 [8] = '{255, 254, 253, 252, 251, 250, 249, 248};
    int g1 [8] = '{9, 9, 9, 9, 9, 9, 9, 9};
    int g2 [8] = '{0, 255, 1, 254, 2, 253, 3, 252};
    int c0, c1, c2;
    n_got = 0;
    send8(g0, 0, c0); send8(g1, 0, c1); send8(g2, 0, c2);
    wait_out(24);
    check(n_got == 24, "R6 no word lost", n_got, 24);
    check_group(0, g0, 0, c0);
    check_group(8, g1, 1, c1);
    check_group(16, g2, 0, c2);
    check(got_c[23] - got_c[0] == 23, "R6 back to back", got_c[23] - got_c[0], 23);
  endtask

  task automatic t_reset_mid();
    int v [8] = '{44, 11, 33, 22, 88, 66, 77, 55};
    int cap;
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_data = W'(200 + i); @(negedge clk);
    end
    in_valid = 0;
    do_reset();
    send8(v, 0, cap);
    wait_out(8);
    check(n_got == 8, "R8 partial group discarded", n_got, 8);
    check_group(0, v, 0, cap);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_single();
    t_alternate();
    t_gaps();
    t_stream();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule